// File: doc/BRIEF.md
# Paged Serial Flash Direct Page Reader

This block is the host-side serial master that fetches bytes from one page of a paged serial flash. It goes straight to the main array and never touches the flash's internal buffers. A caller gives a request made of a page number, a starting byte offset, a byte count and a page-size mode. The mode is either standard, with 528-byte pages, or binary, with 512-byte pages. The block then lowers chip select and shifts out a header of eight bytes: a read opcode, three address bytes and four filler bytes. After the header it clocks in the requested number of data bytes and hands each one out on a valid/ready stream, paired with the offset inside the page that it came from.

The flash wraps to byte 0 of the same page when a read runs past the page end, and the block's offset tracking wraps in the same way. A byte count larger than the page therefore returns the page contents again from the start. The serial clock is made from the system clock by a programmable divider and uses SPI mode 0. Chip select stays low from the first header bit until the consumer has taken the last byte. Then chip select rises and a one-cycle done pulse marks the end of the request.

Back-pressure on the output stream: the block holds one byte at a time. While that byte is offered and not yet taken, `rd_valid`, `rd_data` and `rd_offset` stay unchanged. The serial clock also stops between bytes with chip select still low, so no data can be lost however long the consumer stalls. The request side accepts work only when the block is idle.

Top module: `pgrd_ctrl`

## Requirements
- R1: After reset, and whenever no request is in progress, `spi_cs_n` is 1, `spi_sck` is 0, `rd_valid` is 0, `done` is 0 and `req_ready` is 1.
- R2: The header is sent most significant bit first, in this order: opcode byte 0xD2, three address bytes, then four bytes of 0x00. `spi_mosi` changes only while `spi_sck` is low, and the flash samples it on the rising edge.
- R3: When `req_binary` is 0, the 24 address bits are {1'b0, page[12:0], offset[9:0]}.
- R4: When `req_binary` is 1, the 24 address bits are {2'b00, page[12:0], offset[8:0]}. Bit 9 of `req_offset` is ignored, both for the address and for the returned offsets.
- R5: `spi_cs_n` falls once per request with a non-zero count. It then stays low without a break until the last data byte is accepted, and rises in the same cycle that `done` pulses.
- R6: Each data byte is built from eight `spi_miso` bits sampled on the rising edges of `spi_sck`, most significant bit first. It is delivered on `rd_data` together with the in-page offset it was read from on `rd_offset`.
- R7: After offset 527 in standard mode, or offset 511 in binary mode, the next byte carries offset 0.
- R8: Exactly `req_count` bytes are delivered, even when the count is larger than the page size. The data then repeats from the start of the page.
- R9: A request with `req_count` equal to 0 is accepted and produces a `done` pulse in the next cycle. `spi_cs_n` stays high and no byte is delivered.
- R10: While `rd_valid` is 1 and `rd_ready` is 0, `rd_valid`, `rd_data` and `rd_offset` hold their values and `spi_sck` does not toggle. No byte is lost or overwritten.
- R11: Each high phase and each low phase of `spi_sck` inside a byte lasts `clk_div`+1 system clock cycles.
- R12: `req_ready` is 0 from the acceptance of a request with a non-zero count until its `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_page | input | 13 | Page number to read |
| req_offset | input | 10 | Starting byte offset within the page |
| req_count | input | CNT_W (16) | Number of bytes to return |
| req_binary | input | 1 | 1 selects 512-byte pages, 0 selects 528-byte pages |
| clk_div | input | DIV_W (8) | Serial clock half-period in system cycles, minus one |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| rd_valid | output | 1 | A returned byte is offered |
| rd_ready | input | 1 | Consumer takes the offered byte |
| rd_data | output | 8 | Returned byte |
| rd_offset | output | 10 | In-page offset of the returned byte |
| done | output | 1 | One-cycle pulse at the end of a request |

## Verification
Two events can fall on the same byte: the offset wraps back to zero, and the read ends and chip select is released. This is provoked by a two-byte read that starts at offset 527. The consumer holds off the first byte for a long stall, so the final, wrapped byte is fetched only after the stall ends. The check is that the offsets come out as 527 and then 0, the data matches the flash model's bytes for those offsets, chip select rises only together with done, and the serial clock stays still for the whole stall. Another read runs a page-crossing count under a consumer whose ready signal alternates. Here a handshake on one byte can coincide with the launch of the next, and the check is that no byte is lost or duplicated.

// File: rtl/pgrd_pkg.sv
package pgrd_pkg;
  localparam int BYTE_W    = 8;
  localparam int PAGE_W    = 13;
  localparam int OFF_W     = 10;
  localparam int HDR_BYTES = 8;
  localparam logic [BYTE_W-1:0] OPC_PAGE_READ = 8'hD2;
  localparam logic [OFF_W-1:0]  STD_LAST      = 10'd527;
  localparam logic [OFF_W-1:0]  BIN_LAST      = 10'd511;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HDR,
    ST_DATA
  } pgrd_state_e;

  function automatic logic [23:0] pack_addr(input logic [PAGE_W-1:0] page,
                                            input logic [OFF_W-1:0]  off,
                                            input logic              bin);
    if (bin) pack_addr = {2'b00, page, off[8:0]};
    else     pack_addr = {1'b0, page, off};
  endfunction
endpackage

// File: rtl/pgrd_sck_shift.sv
module pgrd_sck_shift
  import pgrd_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div,
  input  logic              go,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic              busy,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_done
);
  localparam int BIT_W = $clog2(BYTE_W);

  logic [DIV_W-1:0]  hcnt;
  logic [BIT_W-1:0]  bitn;
  logic [BYTE_W-1:0] sh_tx;
  logic [BYTE_W-1:0] sh_rx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      sck     <= 1'b0;
      hcnt    <= '0;
      bitn    <= '0;
      sh_tx   <= '0;
      sh_rx   <= '0;
      rx_done <= 1'b0;
    end else begin
      rx_done <= 1'b0;
      if (!busy) begin
        if (go) begin
          busy  <= 1'b1;
          hcnt  <= '0;
          bitn  <= '0;
          sh_tx <= tx_byte;
        end
      end else if (hcnt == div) begin
        hcnt <= '0;
        if (!sck) begin
          sck   <= 1'b1;
          sh_rx <= {sh_rx[BYTE_W-2:0], miso};
        end else begin
          sck <= 1'b0;
          if (bitn == BIT_W'(BYTE_W - 1)) begin
            busy    <= 1'b0;
            rx_done <= 1'b1;
          end else begin
            bitn  <= bitn + 1'b1;
            sh_tx <= {sh_tx[BYTE_W-2:0], 1'b0};
          end
        end
      end else begin
        hcnt <= hcnt + 1'b1;
      end
    end
  end

  assign mosi    = sh_tx[BYTE_W-1];
  assign rx_byte = sh_rx;

  AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi)); // R2
  AST_SCK_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> busy); // R11
endmodule

// File: rtl/pgrd_frame.sv
module pgrd_frame
  import pgrd_pkg::*;
(
  input  logic [3:0]        idx,
  input  logic [PAGE_W-1:0] page,
  input  logic [OFF_W-1:0]  off,
  input  logic              bin,
  input  logic [OFF_W-1:0]  cur_off,
  output logic [BYTE_W-1:0] tx_byte,
  output logic [OFF_W-1:0]  nxt_off
);
  logic [23:0]       addr;
  logic [BYTE_W-1:0] hdr_b [HDR_BYTES];
  logic [OFF_W-1:0]  last;

  assign addr = pack_addr(page, off, bin);

  for (genvar k = 0; k < HDR_BYTES; k++) begin : g_hdr
    if (k == 0) begin : g_opc
      assign hdr_b[k] = OPC_PAGE_READ;
    end else if (k <= 3) begin : g_adr
      assign hdr_b[k] = addr[8*(3-k) +: 8];
    end else begin : g_pad
      assign hdr_b[k] = '0;
    end
  end

  assign tx_byte = (idx < 4'(HDR_BYTES)) ? hdr_b[idx[2:0]] : '0;
  assign last    = bin ? BIN_LAST : STD_LAST;
  assign nxt_off = (cur_off == last) ? '0 : cur_off + 1'b1;
endmodule

// File: rtl/pgrd_ctrl.sv
module pgrd_ctrl
  import pgrd_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [12:0]       req_page,
  input  logic [9:0]        req_offset,
  input  logic [CNT_W-1:0]  req_count,
  input  logic              req_binary,
  input  logic [DIV_W-1:0]  clk_div,
  output logic              spi_cs_n,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [7:0]        rd_data,
  output logic [9:0]        rd_offset,
  output logic              done
);
  pgrd_state_e       state;
  logic              cs_n_q, done_q;
  logic [3:0]        idx;
  logic [CNT_W-1:0]  left;
  logic [PAGE_W-1:0] page_q;
  logic [OFF_W-1:0]  off_q, cur_off, nxt_off, off_in;
  logic              bin_q;
  logic              rdv_q;
  logic [BYTE_W-1:0] rdd_q;
  logic [OFF_W-1:0]  rdo_q;
  logic              go, eng_busy, rx_done;
  logic [BYTE_W-1:0] tx_byte, rx_byte;
  logic              last_take;

  assign off_in = req_binary ? {1'b0, req_offset[8:0]} : req_offset;

  always_comb begin
    go = 1'b0;
    if (!eng_busy && !rx_done) begin
      if (state == ST_HDR)
        go = (idx < 4'(HDR_BYTES));
      else if (state == ST_DATA)
        go = (left != '0) && (!rdv_q || rd_ready);
    end
  end

  assign last_take = (state == ST_DATA) && (left == '0) && !eng_busy &&
                     !rx_done && rdv_q && rd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cs_n_q  <= 1'b1;
      done_q  <= 1'b0;
      idx     <= '0;
      left    <= '0;
      page_q  <= '0;
      off_q   <= '0;
      cur_off <= '0;
      bin_q   <= 1'b0;
      rdv_q   <= 1'b0;
      rdd_q   <= '0;
      rdo_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (rdv_q && rd_ready) rdv_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            if (req_count == '0) begin
              done_q <= 1'b1;
            end else begin
              page_q  <= req_page;
              off_q   <= off_in;
              cur_off <= off_in;
              bin_q   <= req_binary;
              left    <= req_count;
              idx     <= '0;
              cs_n_q  <= 1'b0;
              state   <= ST_HDR;
            end
          end
        end
        ST_HDR: begin
          if (go) idx <= idx + 1'b1;
          if (rx_done && idx == 4'(HDR_BYTES)) state <= ST_DATA;
        end
        ST_DATA: begin
          if (go) left <= left - 1'b1;
          if (rx_done) begin
            rdv_q   <= 1'b1;
            rdd_q   <= rx_byte;
            rdo_q   <= cur_off;
            cur_off <= nxt_off;
          end
          if (last_take) begin
            cs_n_q <= 1'b1;
            done_q <= 1'b1;
            state  <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  pgrd_frame u_frame (
    .idx     (idx),
    .page    (page_q),
    .off     (off_q),
    .bin     (bin_q),
    .cur_off (cur_off),
    .tx_byte (tx_byte),
    .nxt_off (nxt_off)
  );

  pgrd_sck_shift #(.DIV_W(DIV_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .div     (clk_div),
    .go      (go),
    .tx_byte (tx_byte),
    .miso    (spi_miso),
    .sck     (spi_sck),
    .mosi    (spi_mosi),
    .busy    (eng_busy),
    .rx_byte (rx_byte),
    .rx_done (rx_done)
  );

  assign req_ready = (state == ST_IDLE);
  assign spi_cs_n  = cs_n_q;
  assign rd_valid  = rdv_q;
  assign rd_data   = rdd_q;
  assign rd_offset = rdo_q;
  assign done      = done_q;

  AST_CS_UNTIL_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> ($past(rd_valid && rd_ready) && done)); // R5
  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck); // R1
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data) && $stable(rd_offset))); // R10
  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA && rx_done) |-> !rd_valid); // R10
  AST_ZERO_NO_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_count == '0) |=> (done && spi_cs_n)); // R9
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> !req_ready); // R12
endmodule

// File: tb/pgrd_ctrl_bench.sv
module pgrd_ctrl_bench;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [12:0] req_page = '0;
  logic [9:0]  req_offset = '0;
  logic [15:0] req_count = '0;
  logic        req_binary = 1'b0;
  logic [7:0]  clk_div = 8'd1;
  logic        spi_cs_n, spi_sck, spi_mosi;
  logic        spi_miso = 1'b0;
  logic        rd_valid;
  logic        rd_ready = 1'b0;
  logic [7:0]  rd_data;
  logic [9:0]  rd_offset;
  logic        done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  pgrd_ctrl u_pgrd_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_page(req_page), .req_offset(req_offset), .req_count(req_count),
    .req_binary(req_binary), .clk_div(clk_div), .spi_cs_n(spi_cs_n),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .rd_offset(rd_offset), .done(done)
  );

  function automatic logic [7:0] pat(input logic [12:0] pg, input int of);
    logic [9:0] o;
    o = 10'(of);
    return (o[7:0] ^ {4{o[9:8]}}) + pg[7:0] + 8'h3C;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- flash model ----------------
  bit          mdl_bin = 1'b0;
  logic [63:0] hdr = '0;
  int          bitcnt = 0;
  int          mdl_start = 0;
  int          mdl_psize = 528;
  logic [12:0] mdl_page = '0;
  int          cs_fall = 0, cs_rise = 0, sck_rises = 0, mosi_glitch = 0;

  always @(posedge spi_sck or posedge spi_cs_n) begin
    if (spi_cs_n) begin
      bitcnt = 0;
    end else begin
      sck_rises++;
      if (bitcnt < 64) hdr = {hdr[62:0], spi_mosi};
      bitcnt++;
      if (bitcnt == 64) begin
        mdl_psize = mdl_bin ? 512 : 528;
        if (mdl_bin) begin
          mdl_page  = hdr[53:41];
          mdl_start = int'(hdr[40:32]);
        end else begin
          mdl_page  = hdr[54:42];
          mdl_start = int'(hdr[41:32]);
        end
      end
    end
  end

  always @(negedge spi_sck) begin
    if (!spi_cs_n && bitcnt >= 64) begin
      int k, o;
      logic [7:0] b;
      k = bitcnt - 64;
      o = (mdl_start + k / 8) % mdl_psize;
      b = pat(mdl_page, o);
      spi_miso <= b[7 - (k % 8)];
    end
  end

  always @(negedge spi_cs_n) cs_fall++;
  always @(posedge spi_cs_n) cs_rise++;
  always @(spi_mosi) if (spi_sck && !spi_cs_n) mosi_glitch++;

  // ---------------- sck phase monitor (R11) ----------------
  int cur_div = 1, hi_run = 0, sck_bad = 0;
  always @(negedge clk) begin
    if (spi_sck) hi_run++;
    else if (hi_run > 0) begin
      if (hi_run != cur_div + 1) sck_bad++;
      hi_run = 0;
    end
  end

  // ---------------- watchdog ----------------
  always @(negedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected below 190000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- scenarios ----------------
  task automatic t_reset();
    @(negedge clk);
    chk(spi_cs_n == 1'b1, "R1", "cs_n after reset", int'(spi_cs_n), 1);
    chk(spi_sck == 1'b0, "R1", "sck after reset", int'(spi_sck), 0);
    chk(req_ready == 1'b1, "R1", "req_ready after reset", int'(req_ready), 1);
    chk(rd_valid == 1'b0 && done == 1'b0, "R1", "valid/done after reset",
        int'({rd_valid, done}), 0);
  endtask

  // mode: 0 ready always, 1 ready alternating, 2 long stall on first byte
  task automatic run_read(input logic [12:0] pg, input logic [9:0] off,
                          input int cnt, input bit bin, input int dv,
                          input int mode, input string req);
    int f0, r0, got, cyc, bad_d, bad_o, first_bad, off_eff, psz;
    int first_act, first_exp, stall_moves, stall_bad;
    bit done_seen, ready_bad;
    logic [23:0] exp_addr;
    psz = bin ? 512 : 528;
    off_eff = bin ? int'(off[8:0]) : int'(off);
    exp_addr = bin ? {2'b00, pg, off[8:0]} : {1'b0, pg, off};
    @(negedge clk);
    mdl_bin = bin; cur_div = dv; clk_div = 8'(dv);
    sck_bad = 0; mosi_glitch = 0;
    f0 = cs_fall; r0 = cs_rise;
    req_page = pg; req_offset = off; req_count = 16'(cnt); req_binary = bin;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    got = 0; cyc = 0; bad_d = 0; bad_o = 0; first_bad = -1;
    first_act = 0; first_exp = 0; stall_moves = 0; stall_bad = 0;
    done_seen = 0; ready_bad = 0;
    while (!done_seen && cyc < 60000) begin
      if (done) done_seen = 1;
      else begin
        if (req_ready) ready_bad = 1;
        if (mode == 2 && got == 0 && rd_valid) begin
          logic [7:0] hd;
          logic [9:0] ho;
          int s0;
          hd = rd_data; ho = rd_offset; s0 = sck_rises;
          rd_ready = 1'b0;
          for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (!rd_valid || rd_data != hd || rd_offset != ho) stall_bad++;
          end
          stall_moves = sck_rises - s0;
        end
        rd_ready = (mode == 1) ? cyc[0] : 1'b1;
        if (rd_valid && rd_ready) begin
          int eo;
          eo = (off_eff + got) % psz;
          if (rd_offset != 10'(eo)) bad_o++;
          if (rd_data != pat(pg, eo)) begin
            bad_d++;
            if (first_bad < 0) begin
              first_bad = got; first_act = int'(rd_data); first_exp = int'(pat(pg, eo));
            end
          end
          got++;
        end
        @(negedge clk);
        cyc++;
      end
    end
    rd_ready = 1'b0;
    chk(done_seen, req, "done pulse seen (R5)", int'(done_seen), 1);
    chk(got == cnt, req, "bytes delivered (R8)", got, cnt);
    chk(bad_d == 0, req, "data bytes match flash (R6)", first_act, first_exp);
    chk(bad_o == 0, req, "offset sequence with wrap (R7)", bad_o, 0);
    chk(spi_cs_n == 1'b1, req, "cs_n high with done (R5)", int'(spi_cs_n), 1);
    chk(cs_fall - f0 == 1 && cs_rise - r0 == 1, req, "single cs low window (R5)",
        cs_fall - f0 + cs_rise - r0, 2);
    chk(hdr[63:56] == 8'hD2, req, "opcode (R2)", int'(hdr[63:56]), 'hD2);
    chk(hdr[55:32] == exp_addr, req, bin ? "binary address (R4)" : "standard address (R3)",
        int'(hdr[55:32]), int'(exp_addr));
    chk(hdr[31:0] == 32'h0, req, "dummy bytes zero (R2)", int'(hdr[31:0]), 0);
    chk(mosi_glitch == 0, req, "mosi stable while sck high (R2)", mosi_glitch, 0);
    chk(sck_bad == 0, req, "sck half period (R11)", sck_bad, 0);
    chk(!ready_bad, req, "req_ready low while busy (R12)", int'(ready_bad), 0);
    if (mode == 2) begin
      chk(stall_bad == 0, req, "held byte stable under stall (R10)", stall_bad, 0);
      chk(stall_moves == 0, req, "sck frozen under stall (R10)", stall_moves, 0);
    end
  endtask

  task automatic t_zero();
    int f0;
    f0 = cs_fall;
    @(negedge clk);
    req_count = 16'd0; req_page = 13'h0AA; req_offset = 10'd9; req_binary = 1'b0;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(done == 1'b1, "R9", "done after zero count", int'(done), 1);
    chk(spi_cs_n == 1'b1 && cs_fall == f0, "R9", "cs untouched for zero count",
        cs_fall - f0, 0);
    @(negedge clk);
    chk(done == 1'b0 && rd_valid == 1'b0, "R9", "single pulse, no data",
        int'({done, rd_valid}), 0);
    chk(req_ready == 1'b1, "R1", "idle again after zero count", int'(req_ready), 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    run_read(13'h1A5B, 10'd5,   10,  1'b0, 1, 0, "R3");
    run_read(13'h0F0F, 10'h3FE, 6,   1'b1, 2, 0, "R4");
    run_read(13'h0123, 10'd520, 12,  1'b0, 0, 1, "R7");
    run_read(13'h0777, 10'd3,   530, 1'b0, 0, 0, "R8");
    t_zero();
    run_read(13'h1FFF, 10'd527, 2,   1'b0, 3, 2, "R10");
    t_reset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule